// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Generator

This block sits between a set of interrupt sources and a processor core. Each of up to 31 request lines has a programmable 3-bit priority level. A rising edge on an enabled line is latched as a pending request. The block drives the highest pending level to the core as a 3-bit request. When the core runs an acknowledge cycle for a level, the block picks the pending source at that level and answers with an 8-bit vector number. The vector is a 3-bit base field that software wrote, followed by the 5-bit code of the chosen source.

Every acknowledge receives an answer. If software has not yet written the base register, the answer is the fixed uninitialised vector 0x0F. If the acknowledged level has no pending source, the answer is the spurious vector, which is the base field with all five low bits zero. A single write port holds the base field at address 0 and the per-source priority levels at addresses 1 to 31.

Two small state machines control the block:
- The configuration machine has the states `CFG_BLANK` and `CFG_LIVE`. The transition BLANK→LIVE happens on the first write to address 0, and only reset returns the machine to BLANK.
- The acknowledge machine has the states `ACK_WAIT` and `ACK_REPLY`:
  - WAIT→REPLY on an acknowledge strobe.
  - REPLY→REPLY when another strobe follows immediately.
  - REPLY→WAIT when no strobe follows.

Top module: `irq_vec_gen`

## Requirements
- R1: After reset, `cfg_base_q` reads 0x0F, `vec_vld` is 0, `vec_out` is 0x00, `irq_lvl` is 0 and no request is pending.
- R2: A write to address 0 stores `cfg_wr_data[7:5]` as the base field. From then on `cfg_base_q` reads {base, 5'b00000}, so written bits 4:0 are ignored. This initialised condition is left only through reset.
- R3: A write to address k (1..31) sets the level of source code k, which is line `src_req[k-1]`, to `cfg_wr_data[2:0]`. Level 0 disables the source: its rising edges are not latched and it never contributes to `irq_lvl`.
- R4: A rising edge on an enabled `src_req` bit, sampled at a clock edge, makes the source pending at that edge. A line held high is not latched again. `irq_lvl` is the maximum level among pending sources.
- R5: A one-cycle `ack_stb` produces `vec_vld`=1 with the vector on the next clock. `vec_vld` is high only in the cycle after a strobe.
- R6: An acknowledge before any base write returns 0x0F and clears no pending request.
- R7: After initialisation, an acknowledge of level L returns {base[2:0], code}, where code is the number (index+1) of a pending source with level L.
- R8: Among pending sources with equal level, the lowest-numbered one is chosen.
- R9: After initialisation, an acknowledge returns the spurious vector {base, 5'b00000} when no pending source has level L. This covers L = 0, an empty pending set, and a level that does not match any pending source. No pending request is cleared in this case.
- R10: The chosen source's pending bit clears at the same edge that registers the vector. `irq_lvl` then reflects the remaining sources.
- R11: Back-to-back strobes on consecutive cycles are each answered, in order, with `vec_vld` staying high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 31 | Request lines; bit i is source code i+1 |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 5 | 0 = base register, k = level of source k |
| cfg_wr_data | input | 8 | Write data |
| cfg_base_q | output | 8 | Base register readback |
| ack_stb | input | 1 | One-cycle acknowledge strobe |
| ack_lvl | input | 3 | Level being acknowledged |
| irq_lvl | output | 3 | Highest pending level, 0 when idle |
| vec_out | output | 8 | Vector number returned |
| vec_vld | output | 1 | Vector valid pulse |

## Verification
- A request edge that is applied before clock edge N shows on `irq_lvl` just after edge N.
- A strobe that is applied before edge N gives `vec_vld` and `vec_out` just after edge N, and the pending bit is cleared at that same edge.
- `vec_vld` falls one edge after the strobe is removed.
- Base and level writes take effect at the edge that samples them. The bench drives every input one time unit after a rising edge and samples every output at that same point, so each result is read exactly one edge after its cause.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    // Configuration state: has the base register ever been written
    typedef enum logic {
        CFG_BLANK,
        CFG_LIVE
    } cfg_state_e;

    // Acknowledge handshake state
    typedef enum logic {
        ACK_WAIT,
        ACK_REPLY
    } ack_state_e;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_vec_pkg::*;
#(
    parameter int NUM_SRC = 31,
    parameter int LVL_W   = 3,
    parameter int VEC_W   = 8,
    parameter int BASE_W  = 3,
    parameter int ADDR_W  = 5,
    parameter logic [VEC_W-1:0] RST_VEC = 8'h0F
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [VEC_W-1:0]                wr_data,
    output logic [VEC_W-1:0]                base_q,
    output logic [BASE_W-1:0]               base_field,
    output logic                            live,
    output logic [NUM_SRC-1:0][LVL_W-1:0]   levels,
    output logic [NUM_SRC-1:0]              en_mask
);
    localparam int LOW_W = VEC_W - BASE_W;

    cfg_state_e        st_q, st_d;
    logic              base_wr;
    logic [BASE_W-1:0] base_hi_q;
    logic              unused_wr_bits;

    // Not every data bit feeds a register; the rest are ignored on purpose
    assign unused_wr_bits = ^wr_data;
    assign base_wr = wr_en && (wr_addr == '0);

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CFG_BLANK: if (base_wr) st_d = CFG_LIVE;
            CFG_LIVE:  st_d = CFG_LIVE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CFG_BLANK;
        else        st_q <= st_d;
    end

    // Base field storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       base_hi_q <= RST_VEC[VEC_W-1 -: BASE_W];
        else if (base_wr) base_hi_q <= wr_data[VEC_W-1 -: BASE_W];
    end

    // Outputs derived from the configuration state
    always_comb begin
        live       = (st_q == CFG_LIVE);
        base_field = base_hi_q;
        base_q     = live ? {base_hi_q, {LOW_W{1'b0}}} : RST_VEC;
    end

    // Per-source priority level registers
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
        logic [LVL_W-1:0] lvl_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lvl_q <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(g + 1)))
                lvl_q <= wr_data[LVL_W-1:0];
        end
        assign levels[g]  = lvl_q;
        assign en_mask[g] = |lvl_q;
    end

endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter int NUM_SRC = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] en_mask,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] pend
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic prev_q;
        logic pend_q;
        logic rise;

        assign rise = req[g] && !prev_q && en_mask[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                prev_q <= req[g];
                // A fresh edge wins over a clear in the same cycle
                pend_q <= (pend_q && !clr[g]) || rise;
            end
        end

        assign pend[g] = pend_q;
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NUM_SRC = 31,
    parameter int LVL_W   = 3,
    parameter int CODE_W  = 5
) (
    input  logic [NUM_SRC-1:0]              pend,
    input  logic [NUM_SRC-1:0][LVL_W-1:0]   levels,
    input  logic [LVL_W-1:0]                ack_lvl,
    output logic [LVL_W-1:0]                top_lvl,
    output logic                            hit,
    output logic [CODE_W-1:0]               hit_code,
    output logic [NUM_SRC-1:0]              hit_onehot
);
    logic [CODE_W-1:0] hit_idx;

    // Highest level among pending sources (level 0 never wins)
    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i] && (levels[i] > top_lvl))
                top_lvl = levels[i];
        end
    end

    // Lowest-numbered pending source at the acknowledged level
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i] && (ack_lvl != '0) && (levels[i] == ack_lvl)) begin
                hit     = 1'b1;
                hit_idx = CODE_W'(i);
            end
        end
        hit_code   = hit_idx + CODE_W'(1);
        hit_onehot = hit ? (NUM_SRC'(1) << hit_idx) : '0;
    end

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_vec_pkg::*;
#(
    parameter int NUM_SRC = 31,
    parameter int VEC_W   = 8,
    parameter int BASE_W  = 3,
    parameter int CODE_W  = 5,
    parameter logic [VEC_W-1:0] RST_VEC = 8'h0F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ack_stb,
    input  logic               live,
    input  logic [BASE_W-1:0]  base_field,
    input  logic               hit,
    input  logic [CODE_W-1:0]  hit_code,
    input  logic [NUM_SRC-1:0] hit_onehot,
    output logic [VEC_W-1:0]   vec,
    output logic               vec_vld,
    output logic [NUM_SRC-1:0] clr
);
    ack_state_e       st_q, st_d;
    logic [VEC_W-1:0] answer;
    logic [VEC_W-1:0] vec_q;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ACK_WAIT:  if (ack_stb)  st_d = ACK_REPLY;
            ACK_REPLY: if (!ack_stb) st_d = ACK_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ACK_WAIT;
        else        st_q <= st_d;
    end

    // Vector selection: uninitialised, matched source, or spurious
    always_comb begin
        if (!live)    answer = RST_VEC;
        else if (hit) answer = {base_field, hit_code};
        else          answer = {base_field, {CODE_W{1'b0}}};
    end

    // Vector register, loaded on every strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       vec_q <= '0;
        else if (ack_stb) vec_q <= answer;
    end

    // Outputs
    always_comb begin
        vec     = vec_q;
        vec_vld = (st_q == ACK_REPLY);
        clr     = (ack_stb && live && hit) ? hit_onehot : '0;
    end

endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
    parameter int NUM_SRC = 31,
    parameter int LVL_W   = 3,
    parameter int VEC_W   = 8,
    parameter int BASE_W  = 3,
    parameter logic [VEC_W-1:0] UNINIT_VEC = 8'h0F,
    localparam int CODE_W = VEC_W - BASE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_req,
    input  logic                 cfg_wr_en,
    input  logic [CODE_W-1:0]    cfg_wr_addr,
    input  logic [VEC_W-1:0]     cfg_wr_data,
    output logic [VEC_W-1:0]     cfg_base_q,
    input  logic                 ack_stb,
    input  logic [LVL_W-1:0]     ack_lvl,
    output logic [LVL_W-1:0]     irq_lvl,
    output logic [VEC_W-1:0]     vec_out,
    output logic                 vec_vld
);
    logic [NUM_SRC-1:0][LVL_W-1:0] levels;
    logic [NUM_SRC-1:0]            en_mask;
    logic [NUM_SRC-1:0]            pend;
    logic [NUM_SRC-1:0]            clr;
    logic [NUM_SRC-1:0]            hit_onehot;
    logic [BASE_W-1:0]             base_field;
    logic [CODE_W-1:0]             hit_code;
    logic                          live;
    logic                          hit;

    irq_cfg_regs #(
        .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .VEC_W(VEC_W),
        .BASE_W(BASE_W), .ADDR_W(CODE_W), .RST_VEC(UNINIT_VEC)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
        .base_q(cfg_base_q), .base_field(base_field), .live(live),
        .levels(levels), .en_mask(en_mask)
    );

    irq_edge_latch #(.NUM_SRC(NUM_SRC)) u_latch (
        .clk(clk), .rst_n(rst_n),
        .req(src_req), .en_mask(en_mask), .clr(clr), .pend(pend)
    );

    irq_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .CODE_W(CODE_W)) u_arb (
        .pend(pend), .levels(levels), .ack_lvl(ack_lvl),
        .top_lvl(irq_lvl), .hit(hit), .hit_code(hit_code),
        .hit_onehot(hit_onehot)
    );

    irq_ack_fsm #(
        .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .BASE_W(BASE_W),
        .CODE_W(CODE_W), .RST_VEC(UNINIT_VEC)
    ) u_ack (
        .clk(clk), .rst_n(rst_n),
        .ack_stb(ack_stb), .live(live), .base_field(base_field),
        .hit(hit), .hit_code(hit_code), .hit_onehot(hit_onehot),
        .vec(vec_out), .vec_vld(vec_vld), .clr(clr)
    );

endmodule

// File: rtl/irq_vec_gen_chk.sv
module irq_vec_gen_chk #(
    parameter int NUM_SRC = 31,
    parameter int LVL_W   = 3,
    parameter int VEC_W   = 8,
    parameter int BASE_W  = 3,
    parameter logic [VEC_W-1:0] UNINIT_VEC = 8'h0F,
    localparam int CODE_W = VEC_W - BASE_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SRC-1:0]   src_req,
    input logic                 cfg_wr_en,
    input logic [CODE_W-1:0]    cfg_wr_addr,
    input logic [VEC_W-1:0]     cfg_wr_data,
    input logic [VEC_W-1:0]     cfg_base_q,
    input logic                 ack_stb,
    input logic [LVL_W-1:0]     ack_lvl,
    input logic [LVL_W-1:0]     irq_lvl,
    input logic [VEC_W-1:0]     vec_out,
    input logic                 vec_vld
);
    assert_reply_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb |=> vec_vld);

    assert_no_stray_reply_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld |-> $past(ack_stb));

    assert_uninit_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && (cfg_base_q[CODE_W-1:0] != '0)) |=> (vec_out == UNINIT_VEC));

    assert_base_in_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && (cfg_base_q[CODE_W-1:0] == '0))
        |=> (vec_out[VEC_W-1:CODE_W] == $past(cfg_base_q[VEC_W-1:CODE_W])));

    assert_level0_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && (ack_lvl == '0) && (cfg_base_q[CODE_W-1:0] == '0))
        |=> (vec_out[CODE_W-1:0] == '0));

    assert_low_bits_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_base_q[CODE_W-1:0] == '0) || (cfg_base_q == UNINIT_VEC));

    assert_init_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_base_q[CODE_W-1:0]) == '0) |-> (cfg_base_q[CODE_W-1:0] == '0));

    assert_level_tracks_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req == '0 && !ack_stb) |=> (irq_lvl >= $past(irq_lvl)
            || $past(cfg_wr_en)));

endmodule

bind irq_vec_gen irq_vec_gen_chk #(
    .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .VEC_W(VEC_W),
    .BASE_W(BASE_W), .UNINIT_VEC(UNINIT_VEC)
) u_chk (.*);

// File: tb/sim_irq_vec_gen.sv
module sim_irq_vec_gen;
    localparam int NS = 31;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_req = '0;
    logic          cfg_wr_en = 1'b0;
    logic [4:0]    cfg_wr_addr = '0;
    logic [7:0]    cfg_wr_data = '0;
    logic [7:0]    cfg_base_q;
    logic          ack_stb = 1'b0;
    logic [2:0]    ack_lvl = '0;
    logic [2:0]    irq_lvl;
    logic [7:0]    vec_out;
    logic          vec_vld;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irq_vec_gen u0 (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
        .cfg_wr_data(cfg_wr_data), .cfg_base_q(cfg_base_q),
        .ack_stb(ack_stb), .ack_lvl(ack_lvl), .irq_lvl(irq_lvl),
        .vec_out(vec_out), .vec_vld(vec_vld)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] addr, logic [7:0] data);
        cfg_wr_en = 1'b1; cfg_wr_addr = addr; cfg_wr_data = data;
        tick();
        cfg_wr_en = 1'b0;
    endtask

    task automatic pulse(logic [NS-1:0] mask);
        src_req = src_req | mask;
        tick();
        src_req = src_req & ~mask;
    endtask

    // One-cycle strobe; vector due at the next edge, valid gone one edge later
    task automatic ack(logic [2:0] lvl, logic [7:0] exp_vec, string tag);
        ack_stb = 1'b1; ack_lvl = lvl;
        tick();
        chk({tag, " vld"}, 32'(vec_vld), 32'd1);
        chk({tag, " vec"}, 32'(vec_out), 32'(exp_vec));
        ack_stb = 1'b0; ack_lvl = '0;
        tick();
        chk({tag, " vld drop R5"}, 32'(vec_vld), 32'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 base", 32'(cfg_base_q), 32'h0F);
        chk("R1 vld", 32'(vec_vld), 32'd0);
        chk("R1 vec", 32'(vec_out), 32'h00);
        chk("R1 irq", 32'(irq_lvl), 32'd0);
    endtask

    task automatic t_uninit();
        wr(5'd5, 8'h03);
        pulse(NS'(1) << 4);
        chk("R4 irq after edge", 32'(irq_lvl), 32'd3);
        ack(3'd3, 8'h0F, "R6 uninit");
        chk("R6 still pending", 32'(irq_lvl), 32'd3);
    endtask

    task automatic t_base();
        wr(5'd0, 8'hBF);
        chk("R2 low bits ignored", 32'(cfg_base_q), 32'hA0);
        ack(3'd3, 8'hA5, "R7 single");
        chk("R10 cleared", 32'(irq_lvl), 32'd0);
    endtask

    task automatic t_tie_b2b();
        wr(5'd4, 8'h06);
        wr(5'd9, 8'h06);
        wr(5'd20, 8'h02);
        pulse((NS'(1) << 3) | (NS'(1) << 8) | (NS'(1) << 19));
        chk("R4 max level", 32'(irq_lvl), 32'd6);
        ack_stb = 1'b1; ack_lvl = 3'd6;
        tick();
        chk("R8 lowest first", 32'(vec_out), 32'hA4);
        chk("R11 vld1", 32'(vec_vld), 32'd1);
        tick();
        chk("R11 second", 32'(vec_out), 32'hA9);
        chk("R11 vld2", 32'(vec_vld), 32'd1);
        ack_stb = 1'b0; ack_lvl = '0;
        chk("R10 remaining", 32'(irq_lvl), 32'd2);
        tick();
        chk("R11 vld drop", 32'(vec_vld), 32'd0);
        ack(3'd2, 8'hB4, "R7 code20");
        chk("R10 empty", 32'(irq_lvl), 32'd0);
    endtask

    task automatic t_spurious();
        ack(3'd5, 8'hA0, "R9 empty");
        ack(3'd0, 8'hA0, "R9 level0");
        pulse(NS'(1) << 4);
        ack(3'd7, 8'hA0, "R9 mismatch");
        chk("R9 no clear", 32'(irq_lvl), 32'd3);
        ack(3'd3, 8'hA5, "R7 after mismatch");
        chk("R10 cleared again", 32'(irq_lvl), 32'd0);
    endtask

    task automatic t_disabled();
        pulse(NS'(1) << 1);
        chk("R3 disabled edge", 32'(irq_lvl), 32'd0);
        wr(5'd2, 8'h01);
        chk("R3 not latched earlier", 32'(irq_lvl), 32'd0);
        ack(3'd1, 8'hA0, "R3 nothing pending");
        pulse(NS'(1) << 1);
        chk("R3 enabled edge", 32'(irq_lvl), 32'd1);
        ack(3'd1, 8'hA2, "R3 code2");
    endtask

    task automatic t_held();
        src_req[4] = 1'b1;
        tick();
        chk("R4 held rise", 32'(irq_lvl), 32'd3);
        ack(3'd3, 8'hA5, "R4 held ack");
        tick();
        chk("R4 no relatch", 32'(irq_lvl), 32'd0);
        src_req[4] = 1'b0;
        tick();
        pulse(NS'(1) << 4);
        chk("R4 new edge", 32'(irq_lvl), 32'd3);
        ack(3'd3, 8'hA5, "R4 new edge ack");
    endtask

    task automatic t_rebase();
        wr(5'd0, 8'h1F);
        chk("R2 rewrite", 32'(cfg_base_q), 32'h00);
        ack(3'd4, 8'h00, "R9 zero base");
    endtask

    initial begin
        t_reset();
        t_uninit();
        t_base();
        t_tie_b2b();
        t_spurious();
        t_disabled();
        t_held();
        t_rebase();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule